// File: doc/BRIEF.md
# Tamper Response and Logging Controller

This controller watches eight external tamper pins. A pin that goes to its active level and holds there fires a tamper event. The event pulses wipe strobes towards three destinations: the cipher key storage, the memory-scrambling keys and a small backup register file. The cipher and backup wipes each have their own enable. The scrambler wipe always fires.

Each event sets a sticky per-pin status bit and raises an interrupt. The first event is logged with the time count and the mask of pins that caused it. The controller also holds the backup register file, which can be write-protected, read-protected, or both.

Software clears status and error flags by pulsing write-one-to-clear inputs. It frees the log with a separate clear pulse.

Top module: `tamper_guard`

## Requirements
- R1: Pin i raises an event only while bit i of `src_sel_i` is 1. Bit i of `src_sts_o` and `log_src_o` corresponds to pin i.
- R2: A pin's level is active when it equals `src_pol_i[i]` inverted (0 = active high, 1 = active low). The pin passes through two synchronizer flops. An event needs two consecutive active samples following an inactive one. If a pin turns active before clock edge E0 and stays active, the strobes are high in the cycle after edge E2, for exactly one cycle. A pin that is active for only one cycle causes no event.
- R3: `wipe_scram_o` is high in every event cycle.
- R4: `wipe_key_o` is high in an event cycle only when `clr_key_en_i` is 1.
- R5: `wipe_bkp_o` is high in an event cycle only when `clr_bkp_en_i` is 1. All backup registers then read zero after the next edge, even if a write occurs in the same cycle.
- R6: An event sets the sticky bits of its pins in `src_sts_o`. A 1 in `sts_clr_i` clears the matching bit, but a set in the same cycle wins. `irq_o` is high while any status bit is set.
- R7: With the log empty, an event sets `log_valid_o` and stores `time_cnt_i` from the event cycle and the event's pin mask.
- R8: An event while the log is valid sets sticky `log_ovf_o` and leaves the log unchanged. `log_clr_i` empties the log and clears the overflow. An event in the same cycle as `log_clr_i` is captured as a fresh entry.
- R9: A write while `bkp_wprot_i` is 1 changes no register and sets sticky `acc_err_o`. `err_clr_i` clears it, and a new error in the same cycle wins.
- R10: `bkp_rdata_o` combinationally shows the register at `bkp_addr_i`, or zero while `bkp_rprot_i` is 1.
- R11: After reset, all status, log and error outputs and all backup registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_i | input | 8 | Raw tamper pins |
| time_cnt_i | input | 32 | Free-running time count |
| src_sel_i | input | 8 | Per-pin source select |
| src_pol_i | input | 8 | Per-pin polarity, 1 = active low |
| clr_key_en_i | input | 1 | Enable cipher key wipe |
| clr_bkp_en_i | input | 1 | Enable backup file wipe |
| bkp_wprot_i | input | 1 | Backup write protection |
| bkp_rprot_i | input | 1 | Backup read protection |
| bkp_we_i | input | 1 | Backup write strobe |
| bkp_addr_i | input | 3 | Backup register address |
| bkp_wdata_i | input | 32 | Backup write data |
| bkp_rdata_o | output | 32 | Backup read data |
| sts_clr_i | input | 8 | Write-one-to-clear for status bits |
| log_clr_i | input | 1 | Empty the log and clear overflow |
| err_clr_i | input | 1 | Clear access error |
| wipe_key_o | output | 1 | Cipher key wipe strobe |
| wipe_scram_o | output | 1 | Scrambling key wipe strobe |
| wipe_bkp_o | output | 1 | Backup file wipe strobe |
| src_sts_o | output | 8 | Sticky per-pin status |
| irq_o | output | 1 | Interrupt |
| log_valid_o | output | 1 | Log holds an entry |
| log_time_o | output | 32 | Logged time |
| log_src_o | output | 8 | Logged pin mask |
| log_ovf_o | output | 1 | Sticky log overflow |
| acc_err_o | output | 1 | Sticky access error |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a backup wipe and a software write to the backup file. The bench places a write exactly in a strobe cycle and then reads that address back. It must read zero.

The second pair is a log clear and a new tamper event. The bench times the clear to match a strobe cycle. It then expects the log to hold the new pin mask with the overflow flag clear.

Random traffic lets both collisions, and status clears that meet new events, also arise freely. Every cycle is compared against a bench model.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic {TG_ACT_HIGH = 1'b0, TG_ACT_LOW = 1'b1} tg_pol_e;

  // level after polarity correction: 1 means the pin is in its tamper state
  function automatic logic tg_active(input logic raw, input tg_pol_e pol);
    return (pol == TG_ACT_LOW) ? ~raw : raw;
  endfunction
endpackage

// File: rtl/tg_rst_sync.sv
module tg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/tg_pin_filter.sv
module tg_pin_filter
  import tg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic pol_i,
  input  logic pin_i,
  output logic event_o
);
  // [0],[1] synchronizer; [2],[3] history for stability and edge
  logic [3:0] pipe_q;
  logic [3:0] pipe_d;
  logic       lvl_now, lvl_prev, lvl_old;

  always_comb pipe_d = {pipe_q[2:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_comb begin
    lvl_now  = tg_active(pipe_q[1], tg_pol_e'(pol_i));
    lvl_prev = tg_active(pipe_q[2], tg_pol_e'(pol_i));
    lvl_old  = tg_active(pipe_q[3], tg_pol_e'(pol_i));
    event_o  = sel_i & lvl_now & lvl_prev & ~lvl_old;
  end
endmodule

// File: rtl/tg_event_log.sv
module tg_event_log #(
  parameter int PINS   = 8,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   evt_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [PINS-1:0]   sts_clr_i,
  input  logic              log_clr_i,
  output logic [PINS-1:0]   sts_o,
  output logic              valid_o,
  output logic [TIME_W-1:0] time_o,
  output logic [PINS-1:0]   src_o,
  output logic              ovf_o
);
  logic [PINS-1:0]   sts_q, sts_d, src_q, src_d;
  logic [TIME_W-1:0] time_q, time_d;
  logic              valid_q, valid_d, ovf_q, ovf_d;
  logic              any_evt;

  always_comb begin
    any_evt = |evt_i;
    sts_d   = (sts_q & ~sts_clr_i) | evt_i;
    valid_d = log_clr_i ? 1'b0 : valid_q;
    ovf_d   = log_clr_i ? 1'b0 : ovf_q;
    time_d  = time_q;
    src_d   = src_q;
    if (any_evt) begin
      if (!valid_d) begin
        valid_d = 1'b1;
        time_d  = time_i;
        src_d   = evt_i;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      src_q   <= '0;
      time_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      src_q   <= src_d;
      time_q  <= time_d;
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  assign sts_o   = sts_q;
  assign valid_o = valid_q;
  assign time_o  = time_q;
  assign src_o   = src_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tg_backup_file.sv
module tg_backup_file #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          wprot_i,
  input  logic          rprot_i,
  input  logic          err_clr_i,
  output logic [W-1:0]  rdata_o,
  output logic          err_o
);
  logic [W-1:0] regs_q [DEPTH];
  logic [W-1:0] regs_d [DEPTH];
  logic         err_q, err_d;
  logic         addr_ok;

  always_comb begin
    addr_ok = int'(addr_i) < DEPTH;
    err_d   = (err_q & ~err_clr_i) | (we_i & wprot_i);
    for (int i = 0; i < DEPTH; i++) begin
      if (wipe_i)
        regs_d[i] = '0;
      else if (we_i && !wprot_i && addr_ok && int'(addr_i) == i)
        regs_d[i] = wdata_i;
      else
        regs_d[i] = regs_q[i];
    end
    rdata_o = '0;
    if (!rprot_i && addr_ok) rdata_o = regs_q[addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else begin
      err_q <= err_d;
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter  int PINS      = 8,
  parameter  int TIME_W    = 32,
  parameter  int BKP_DEPTH = 8,
  parameter  int BKP_W     = 32,
  localparam int BKP_AW    = (BKP_DEPTH > 1) ? $clog2(BKP_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   tamper_i,
  input  logic [TIME_W-1:0] time_cnt_i,
  input  logic [PINS-1:0]   src_sel_i,
  input  logic [PINS-1:0]   src_pol_i,
  input  logic              clr_key_en_i,
  input  logic              clr_bkp_en_i,
  input  logic              bkp_wprot_i,
  input  logic              bkp_rprot_i,
  input  logic              bkp_we_i,
  input  logic [BKP_AW-1:0] bkp_addr_i,
  input  logic [BKP_W-1:0]  bkp_wdata_i,
  output logic [BKP_W-1:0]  bkp_rdata_o,
  input  logic [PINS-1:0]   sts_clr_i,
  input  logic              log_clr_i,
  input  logic              err_clr_i,
  output logic              wipe_key_o,
  output logic              wipe_scram_o,
  output logic              wipe_bkp_o,
  output logic [PINS-1:0]   src_sts_o,
  output logic              irq_o,
  output logic              log_valid_o,
  output logic [TIME_W-1:0] log_time_o,
  output logic [PINS-1:0]   log_src_o,
  output logic              log_ovf_o,
  output logic              acc_err_o
);
  logic            rst_int_n;
  logic [PINS-1:0] evt;
  logic            any_evt;

  tg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    tg_pin_filter u_flt (
      .clk(clk), .rst_n(rst_int_n), .sel_i(src_sel_i[p]),
      .pol_i(src_pol_i[p]), .pin_i(tamper_i[p]), .event_o(evt[p])
    );
  end

  always_comb begin
    any_evt      = |evt;
    wipe_scram_o = any_evt;
    wipe_key_o   = any_evt & clr_key_en_i;
    wipe_bkp_o   = any_evt & clr_bkp_en_i;
  end

  tg_event_log #(.PINS(PINS), .TIME_W(TIME_W)) u_log (
    .clk(clk), .rst_n(rst_int_n), .evt_i(evt), .time_i(time_cnt_i),
    .sts_clr_i(sts_clr_i), .log_clr_i(log_clr_i), .sts_o(src_sts_o),
    .valid_o(log_valid_o), .time_o(log_time_o), .src_o(log_src_o),
    .ovf_o(log_ovf_o)
  );

  assign irq_o = |src_sts_o;

  tg_backup_file #(.DEPTH(BKP_DEPTH), .W(BKP_W), .AW(BKP_AW)) u_bkp (
    .clk(clk), .rst_n(rst_int_n), .wipe_i(wipe_bkp_o), .we_i(bkp_we_i),
    .addr_i(bkp_addr_i), .wdata_i(bkp_wdata_i), .wprot_i(bkp_wprot_i),
    .rprot_i(bkp_rprot_i), .err_clr_i(err_clr_i), .rdata_o(bkp_rdata_o),
    .err_o(acc_err_o)
  );
endmodule

// File: rtl/tg_guard_checker.sv
module tg_guard_checker #(
  parameter int PINS   = 8,
  parameter int TIME_W = 32,
  parameter int BKP_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wipe_key_o,
  input logic              wipe_scram_o,
  input logic              wipe_bkp_o,
  input logic              clr_key_en_i,
  input logic              clr_bkp_en_i,
  input logic              irq_o,
  input logic              log_valid_o,
  input logic [TIME_W-1:0] log_time_o,
  input logic [PINS-1:0]   log_src_o,
  input logic              log_clr_i,
  input logic              bkp_we_i,
  input logic              bkp_wprot_i,
  input logic              acc_err_o,
  input logic [BKP_W-1:0]  bkp_rdata_o
);
  assert_key_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_key_o |-> (wipe_scram_o && clr_key_en_i));

  assert_bkp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_bkp_o |-> (wipe_scram_o && clr_bkp_en_i));

  assert_bkp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_bkp_o |=> (bkp_rdata_o == '0));

  assert_irq_after_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_scram_o |=> irq_o);

  assert_log_filled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_scram_o |=> log_valid_o);

  assert_log_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && !log_clr_i) |=> ($stable(log_time_o) && $stable(log_src_o) && log_valid_o));

  assert_wprot_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bkp_we_i && bkp_wprot_i) |=> acc_err_o);
endmodule

bind tamper_guard tg_guard_checker #(.PINS(PINS), .TIME_W(TIME_W), .BKP_W(BKP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wipe_key_o(wipe_key_o), .wipe_scram_o(wipe_scram_o),
  .wipe_bkp_o(wipe_bkp_o), .clr_key_en_i(clr_key_en_i), .clr_bkp_en_i(clr_bkp_en_i),
  .irq_o(irq_o), .log_valid_o(log_valid_o), .log_time_o(log_time_o),
  .log_src_o(log_src_o), .log_clr_i(log_clr_i), .bkp_we_i(bkp_we_i),
  .bkp_wprot_i(bkp_wprot_i), .acc_err_o(acc_err_o), .bkp_rdata_o(bkp_rdata_o)
);

// File: tb/test_tamper_guard.sv
`timescale 1ns/1ps
module test_tamper_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tamper, src_sel, src_pol, sts_clr;
  logic [31:0] tcnt, wdata, rdata, log_time;
  logic        key_en, bkp_en, wprot, rprot, we, log_clr, err_clr;
  logic [2:0]  addr;
  logic        w_key, w_scram, w_bkp, irq, log_valid, log_ovf, acc_err;
  logic [7:0]  sts, log_src;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [7:0]  m_s1, m_s2, m_s3, m_s4, m_sts, m_src, m_evt;
  logic [31:0] m_time;
  logic        m_valid, m_ovf, m_err;
  logic [31:0] m_bkp [8];

  always #5 clk = ~clk;

  tamper_guard i_tamper_guard (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper), .time_cnt_i(tcnt),
    .src_sel_i(src_sel), .src_pol_i(src_pol), .clr_key_en_i(key_en),
    .clr_bkp_en_i(bkp_en), .bkp_wprot_i(wprot), .bkp_rprot_i(rprot),
    .bkp_we_i(we), .bkp_addr_i(addr), .bkp_wdata_i(wdata), .bkp_rdata_o(rdata),
    .sts_clr_i(sts_clr), .log_clr_i(log_clr), .err_clr_i(err_clr),
    .wipe_key_o(w_key), .wipe_scram_o(w_scram), .wipe_bkp_o(w_bkp),
    .src_sts_o(sts), .irq_o(irq), .log_valid_o(log_valid), .log_time_o(log_time),
    .log_src_o(log_src), .log_ovf_o(log_ovf), .acc_err_o(acc_err)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] act_lvl(input logic [7:0] raw, input logic [7:0] pol);
    return raw ^ pol;
  endfunction

  // one cycle: check outputs against model, advance model, wait for next negedge
  task automatic tick();
    logic any;
    #1;
    m_evt = src_sel & act_lvl(m_s2, src_pol) & act_lvl(m_s3, src_pol) & ~act_lvl(m_s4, src_pol);
    any   = |m_evt;
    chk("R2 R3", "wipe_scram", w_scram, any);
    chk("R4", "wipe_key", w_key, any & key_en);
    chk("R5", "wipe_bkp", w_bkp, any & bkp_en);
    chk("R1 R6", "src_sts", sts, m_sts);
    chk("R6", "irq", irq, |m_sts);
    chk("R7", "log_valid", log_valid, m_valid);
    chk("R7", "log_time", log_time, m_time);
    chk("R1 R7", "log_src", log_src, m_src);
    chk("R8", "log_ovf", log_ovf, m_ovf);
    chk("R9", "acc_err", acc_err, m_err);
    chk("R10", "rdata", rdata, rprot ? 32'h0 : m_bkp[addr]);
    // model update for the coming edge
    m_sts = (m_sts & ~sts_clr) | m_evt;
    if (log_clr) begin m_valid = 1'b0; m_ovf = 1'b0; end
    if (any) begin
      if (!m_valid) begin m_valid = 1'b1; m_time = tcnt; m_src = m_evt; end
      else m_ovf = 1'b1;
    end
    m_err = (m_err & ~err_clr) | (we & wprot);
    if (any && bkp_en) begin
      for (int i = 0; i < 8; i++) m_bkp[i] = '0;
    end else if (we && !wprot) begin
      m_bkp[addr] = wdata;
    end
    m_s4 = m_s3; m_s3 = m_s2; m_s2 = m_s1; m_s1 = tamper;
    @(negedge clk);
    tcnt = tcnt + 32'd1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    tamper = '0; src_sel = '0; src_pol = '0; sts_clr = '0; tcnt = 32'h100;
    wdata = '0; key_en = 0; bkp_en = 0; wprot = 0; rprot = 0; we = 0;
    log_clr = 0; err_clr = 0; addr = '0;
    m_s1 = '0; m_s2 = '0; m_s3 = '0; m_s4 = '0; m_sts = '0; m_src = '0;
    m_time = '0; m_valid = 0; m_ovf = 0; m_err = 0;
    for (int i = 0; i < 8; i++) m_bkp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(5);
    // R11: reset state
    #1;
    chk("R11", "src_sts", sts, 8'h0);
    chk("R11", "irq", irq, 1'b0);
    chk("R11", "log_valid", log_valid, 1'b0);
    chk("R11", "acc_err", acc_err, 1'b0);
    chk("R11", "rdata", rdata, 32'h0);

    for (int i = 0; i < 8; i++) begin
      we = 1; addr = 3'(i); wdata = 32'hA500_0000 + 32'(i); tick();
    end
    we = 0;
    src_sel = 8'h7F;

    // one-cycle glitch on pin 0 is filtered
    tamper[0] = 1; tick(); tamper[0] = 0; run(6);
    chk("R2", "glitch status", sts, 8'h0);

    // deselected pin 7
    tamper[7] = 1; run(6);
    chk("R1", "deselected status", sts, 8'h0);
    tamper[7] = 0; run(5);

    // event on pin 2, wipes disabled
    tamper[2] = 1; run(8);
    addr = 3'd2; #1;
    chk("R5", "backup kept", rdata, 32'hA500_0002);
    chk("R7", "log src", log_src, 8'h04);
    tick();
    tamper[2] = 0; run(5);

    // event on pin 3 with wipes enabled, write in the strobe cycle
    key_en = 1; bkp_en = 1;
    tamper[3] = 1; run(3);
    we = 1; addr = 3'd5; wdata = 32'hDEAD_BEEF; tick();
    we = 0; #1;
    chk("R5", "write vs wipe", rdata, 32'h0);
    chk("R8", "overflow", log_ovf, 1'b1);
    chk("R8", "log kept", log_src, 8'h04);
    tick();
    sts_clr = 8'hFF; log_clr = 1; err_clr = 1; tick();
    sts_clr = '0; log_clr = 0; err_clr = 0;
    tamper[3] = 0; run(5);

    // pin 4 active low; log clear in the same cycle as its event
    src_sel = 8'h6F; tamper[4] = 1; run(5);
    src_pol = 8'h10; run(2);
    src_sel = 8'h7F; run(2);
    tamper[1] = 1; run(8); tamper[1] = 0; run(5);
    tamper[4] = 0; run(3);
    log_clr = 1; tick(); log_clr = 0; #1;
    chk("R8", "clear+event src", log_src, 8'h10);
    chk("R8", "clear+event ovf", log_ovf, 1'b0);
    tick();
    tamper[4] = 1; run(5);

    // protection
    wprot = 0; we = 1; addr = 3'd1; wdata = 32'h1111_1111; tick();
    wprot = 1; wdata = 32'h2222_2222; tick();
    we = 0; #1;
    chk("R9", "protected write", rdata, 32'h1111_1111);
    chk("R9", "error flag", acc_err, 1'b1);
    rprot = 1; #1;
    chk("R10", "read protected", rdata, 32'h0);
    tick();
    rprot = 0; wprot = 0; err_clr = 1; tick(); err_clr = 0;

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < 8; p++)
        if ($urandom_range(0, 7) == 0) tamper[p] = ~tamper[p];
      if ($urandom_range(0, 199) == 0) src_sel = 8'($urandom);
      if ($urandom_range(0, 299) == 0) src_pol = 8'($urandom);
      key_en  = ($urandom_range(0, 1) == 1);
      bkp_en  = ($urandom_range(0, 2) == 0);
      wprot   = ($urandom_range(0, 3) == 0);
      rprot   = ($urandom_range(0, 3) == 0);
      we      = ($urandom_range(0, 2) == 0);
      addr    = 3'($urandom);
      wdata   = $urandom;
      sts_clr = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'h0;
      log_clr = ($urandom_range(0, 19) == 0);
      err_clr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 3) == 0) tcnt = tcnt + 32'($urandom_range(0, 50));
      tick();
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule